// File: doc/BRIEF.md
# Count-to-Limit Interval Timer

This block is a 32-bit interval timer with three registers on a simple single-cycle write bus and a combinational read port: a count register, a limit register and a control register. When the run bit in control is set, the count advances by one on every clock. When the count is equal to the limit, the next running clock returns the count to zero and latches a pending flag. The level-sensitive interrupt output is high while that flag is set and interrupts are enabled.

Software acknowledges an interrupt by writing the control register. Any control write clears the pending flag and loads the enable and run bits from the write data, so acknowledging and rearming take a single access. If the limit is programmed to all ones and interrupts are left disabled, the block is a free-running counter that wraps modulo 2^32. Software can rewrite the count at any time, for example to restart an interval from zero.

Top module: `ivt_top`

## Requirements
- R1: After reset, count, limit and control all read zero, the timer is halted and `irq` is low.
- R2: Reads are decoded by `addr`: 0 returns the count, 1 returns the limit, 2 returns control with interrupt enable in bit 0, run in bit 1 and pending in bit 3 (all other bits zero), and 3 returns zero.
- R3: While the run bit is set and the count differs from the limit, the count increases by one per clock. While the run bit is clear, the count holds its value.
- R4: While running with the count equal to the limit, the next clock sets the count to zero and sets the pending flag.
- R5: `irq` is a level that is high exactly while both the pending flag and the interrupt enable are set.
- R6: A write to control (`addr` 2) loads interrupt enable from data bit 0 and run from data bit 1, and clears the pending flag. Data bit 3 never sets the pending flag.
- R7: A write to count (`addr` 0) or to limit (`addr` 1) takes effect on that clock and overrides the increment or the wrap to zero that would otherwise occur.
- R8: With the limit at all ones, the count runs from 0xFFFFFFFF to 0 and sets the pending flag. With interrupt enable clear, `irq` stays low.
- R9: With the limit at zero and the timer running, the count stays at zero and the pending flag is set on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one write per clock |
| addr | input | 2 | Register select for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the register selected by `addr` |
| irq | output | 1 | Level interrupt request |

## Verification
A corrupt count shows up at the read port on the clock after the fault. It then stays visible, because each later value is derived from it. A wrong pending or enable bit is visible in the same cycle on `irq` and on the control readback. A wrong match decision shifts the point where the count returns to zero, which makes a mismatch at the exact cycle where the wrap is expected. For this reason the bench reads the count and `irq` on specific cycles around every limit crossing and every control write.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_COUNT = 2'd0;
    localparam logic [ADDR_W-1:0] A_LIMIT = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd2;

    localparam int IE_BIT   = 0;
    localparam int RUN_BIT  = 1;
    localparam int PEND_BIT = 3;
endpackage

// File: rtl/ivt_regdec.sv
module ivt_regdec
    import ivt_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              cnt_we,
    output logic              lim_we,
    output logic              ctl_we
);
    always_comb begin
        cnt_we = wr_en && (addr == A_COUNT);
        lim_we = wr_en && (addr == A_LIMIT);
        ctl_we = wr_en && (addr == A_CTRL);
    end
endmodule

// File: rtl/ivt_core.sv
module ivt_core
    import ivt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_we,
    input  logic         lim_we,
    input  logic         ctl_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] lim_o,
    output logic         ie_o,
    output logic         run_o,
    output logic         pend_o
);
    localparam logic [W-1:0] STEP = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] lim;
        logic         ie;
        logic         run;
        logic         pend;
    } state_t;

    state_t st_d, st_q;
    logic   hit;

    always_comb begin
        st_d = st_q;
        hit  = (st_q.cnt == st_q.lim);
        // advance or wrap when running
        if (st_q.run) begin
            if (hit) begin
                st_d.cnt  = '0;
                st_d.pend = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + STEP;
            end
        end
        // software writes win over the counter path
        if (cnt_we) st_d.cnt = wdata;
        if (lim_we) st_d.lim = wdata;
        if (ctl_we) begin
            st_d.ie   = wdata[IE_BIT];
            st_d.run  = wdata[RUN_BIT];
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign lim_o  = st_q.lim;
    assign ie_o   = st_q.ie;
    assign run_o  = st_q.run;
    assign pend_o = st_q.pend;
endmodule

// File: rtl/ivt_rdmux.sv
module ivt_rdmux
    import ivt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      cnt,
    input  logic [W-1:0]      lim,
    input  logic              ie,
    input  logic              run,
    input  logic              pend,
    output logic [W-1:0]      rdata
);
    logic [W-1:0] ctl_word;

    always_comb begin
        ctl_word           = '0;
        ctl_word[IE_BIT]   = ie;
        ctl_word[RUN_BIT]  = run;
        ctl_word[PEND_BIT] = pend;
        case (addr)
            A_COUNT: rdata = cnt;
            A_LIMIT: rdata = lim;
            A_CTRL:  rdata = ctl_word;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/ivt_top.sv
module ivt_top
    import ivt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    output logic              irq
);
    logic         cnt_we, lim_we, ctl_we;
    logic [W-1:0] cnt_q, lim_q;
    logic         ie_q, run_q, pend_q;

    ivt_regdec u_dec (
        .wr_en  (wr_en),
        .addr   (addr),
        .cnt_we (cnt_we),
        .lim_we (lim_we),
        .ctl_we (ctl_we)
    );

    ivt_core #(.W(W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_we (cnt_we),
        .lim_we (lim_we),
        .ctl_we (ctl_we),
        .wdata  (wdata),
        .cnt_o  (cnt_q),
        .lim_o  (lim_q),
        .ie_o   (ie_q),
        .run_o  (run_q),
        .pend_o (pend_q)
    );

    ivt_rdmux #(.W(W)) u_rd (
        .addr  (addr),
        .cnt   (cnt_q),
        .lim   (lim_q),
        .ie    (ie_q),
        .run   (run_q),
        .pend  (pend_q),
        .rdata (rdata)
    );

    assign irq = pend_q & ie_q;
endmodule

// File: rtl/ivt_chk.sv
module ivt_chk
    import ivt_pkg::*;
#(
    parameter int W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [W-1:0]      wdata,
    input logic              irq,
    input logic [W-1:0]      cnt_q,
    input logic [W-1:0]      lim_q,
    input logic              run_q,
    input logic              pend_q
);
    logic wr_cnt, wr_ctl;
    assign wr_cnt = wr_en && (addr == A_COUNT);
    assign wr_ctl = wr_en && (addr == A_CTRL);

    // R3: halted timer keeps its count
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_cnt) |=> $stable(cnt_q));

    // R3: running, below match, steps by one
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != lim_q && !wr_cnt) |=> (cnt_q == $past(cnt_q) + W'(1)));

    // R4: match returns count to zero
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q == lim_q && !wr_cnt) |=> (cnt_q == '0));

    // R4: match raises pending unless acknowledged in the same cycle
    a_r4_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q == lim_q && !wr_ctl) |=> pend_q);

    // R6: control write acknowledges
    a_r6_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> (!pend_q && !irq));

    // R7: software count write wins
    a_r7_cnt_wr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_q == $past(wdata)));
endmodule

bind ivt_top ivt_chk #(.W(W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .irq    (irq),
    .cnt_q  (cnt_q),
    .lim_q  (lim_q),
    .run_q  (run_q),
    .pend_q (pend_q)
);

// File: tb/ivt_top_tb_top.sv
`timescale 1ns/1ps
module ivt_top_tb_top;
    localparam logic [1:0] KW = 2'd0;  // write, one clock
    localparam logic [1:0] KC = 2'd1;  // check rdata and irq, no clock
    localparam logic [1:0] KN = 2'd2;  // idle clock
    localparam logic [1:0] AC = 2'd0, AL = 2'd1, AT = 2'd2;
    localparam int NV = 32;

    // {kind, addr, data/expected, expected irq, requirement number}
    localparam logic [40:0] VEC [NV] = '{
        {KW, AL, 32'h3, 1'b0, 4'd2},
        {KC, AL, 32'h3, 1'b0, 4'd2},          // R2 limit readback
        {KW, AC, 32'h0, 1'b0, 4'd7},
        {KW, AT, 32'h3, 1'b0, 4'd6},
        {KC, AC, 32'h0, 1'b0, 4'd3},
        {KN, AC, 32'h0, 1'b0, 4'd3},
        {KC, AC, 32'h1, 1'b0, 4'd3},          // R3 step
        {KN, AC, 32'h0, 1'b0, 4'd3},
        {KN, AC, 32'h0, 1'b0, 4'd3},
        {KC, AC, 32'h3, 1'b0, 4'd3},
        {KN, AC, 32'h0, 1'b0, 4'd4},
        {KC, AC, 32'h0, 1'b1, 4'd4},          // R4 wrap and R5 irq
        {KC, AT, 32'hB, 1'b1, 4'd2},          // R2 control layout
        {KN, AC, 32'h0, 1'b0, 4'd5},
        {KC, AC, 32'h1, 1'b1, 4'd5},          // R5 level holds
        {KW, AT, 32'h3, 1'b0, 4'd6},          // ack and rearm
        {KC, AT, 32'h3, 1'b0, 4'd6},
        {KC, AC, 32'h2, 1'b0, 4'd6},
        {KW, AT, 32'h2, 1'b0, 4'd5},          // run, ie off
        {KN, AC, 32'h0, 1'b0, 4'd5},
        {KC, AT, 32'hA, 1'b0, 4'd5},          // R5 pending without enable
        {KW, AT, 32'h8, 1'b0, 4'd6},          // bit 3 must not set pending
        {KC, AT, 32'h0, 1'b0, 4'd6},
        {KN, AC, 32'h0, 1'b0, 4'd3},
        {KC, AC, 32'h1, 1'b0, 4'd3},          // R3 hold while halted
        {KW, AT, 32'h2, 1'b0, 4'd7},
        {KW, AC, 32'h100, 1'b0, 4'd7},        // R7 overrides increment
        {KC, AC, 32'h100, 1'b0, 4'd7},
        {KW, AT, 32'h0, 1'b0, 4'd3},
        {KC, AC, 32'h101, 1'b0, 4'd3},
        {KC, 2'd3, 32'h0, 1'b0, 4'd2},        // R2 unused address
        {KC, AL, 32'h3, 1'b0, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    ivt_top dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic put(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic look(input logic [1:0] a, input logic [31:0] ed,
                        input logic ei, input string req);
        addr = a;
        #0.1;
        n_chk++;
        if (rdata !== ed || irq !== ei) begin
            n_bad++;
            $display("FAIL %s addr %0d: rdata %h irq %b, expected rdata %h irq %b",
                     req, a, rdata, irq, ed, ei);
        end
    endtask

    initial begin
        #50000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        look(AC, 32'h0, 1'b0, "R1");
        look(AL, 32'h0, 1'b0, "R1");
        look(AT, 32'h0, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][40:39])
                KW: put(VEC[i][38:37], VEC[i][36:5]);
                KN: tick();
                default: look(VEC[i][38:37], VEC[i][36:5], VEC[i][4],
                              $sformatf("R%0d", VEC[i][3:0]));
            endcase
        end

        // R8 free-running wrap at all-ones limit
        put(AL, 32'hFFFF_FFFF);
        put(AC, 32'hFFFF_FFFE);
        put(AT, 32'h2);
        look(AC, 32'hFFFF_FFFE, 1'b0, "R8");
        tick();
        look(AC, 32'hFFFF_FFFF, 1'b0, "R8");
        tick();
        look(AC, 32'h0, 1'b0, "R8");
        look(AT, 32'hA, 1'b0, "R8");
        tick();
        look(AC, 32'h1, 1'b0, "R8");

        // R9 zero limit
        put(AT, 32'h0);
        put(AL, 32'h0);
        put(AC, 32'h0);
        put(AT, 32'h3);
        look(AT, 32'h3, 1'b0, "R9");
        tick();
        look(AC, 32'h0, 1'b1, "R9");
        tick();
        look(AC, 32'h0, 1'b1, "R9");

        // R7 limit write on a running clock
        put(AT, 32'h2);
        put(AL, 32'h5);
        look(AL, 32'h5, 1'b0, "R7");
        look(AC, 32'h0, 1'b0, "R7");

        // R1 reset mid-run
        rst_n = 1'b0;
        #1;
        look(AT, 32'h0, 1'b0, "R1");
        look(AL, 32'h0, 1'b0, "R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule